// File: doc/BRIEF.md
# ALU Status Flag Generator

This block computes the result of an 8-bit or 16-bit add, subtract or logical operation and derives the six arithmetic status flags from it. The flags are carry, parity, auxiliary carry, zero, sign and overflow. These are kept in a 16-bit flags word next to three control flags: single-step, interrupt-enable and direction. Only dedicated set and clear inputs change the control flags, and no arithmetic operation ever changes them.

The result is combinational. It follows the operands, operation select and size select in the same cycle. On a clock edge where the update enable is high, the block captures the status flags for that result into the flags register. There is no back-pressure. The block can take a new operation on every cycle, so the update enable serves as the valid qualifier, and no ready signal exists. The flags word is always readable.

Top module: `alu_flag_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `flags` reads 16'h0002. Every status flag and every control flag is 0.
- R2: `op_sel` encodes the operation as 0 = add, 1 = subtract (a minus b), 2 = bitwise AND, 3 = bitwise XOR. `result` shows the outcome in the same cycle. When `size_byte` is 1, only the low 8 bits of the operands take part and `result[15:8]` reads 0.
- R3: Carry (bit 0) is set on a carry out of the most significant bit of the operation size (bit 7 or bit 15) for add, or a borrow into it for subtract.
- R4: Auxiliary carry (bit 4) is set on a carry out of bit 3 for add, or a borrow into bit 3 for subtract.
- R5: Overflow (bit 11) is set when the signed result cannot be represented in the selected size. Add overflows when both operands have the same sign and the result sign differs. Subtract overflows when the operand signs differ and the result sign differs from that of a.
- R6: Zero (bit 6) is set when the result within the selected size is zero. Sign (bit 7) copies bit 7 of the result in byte mode and bit 15 in word mode.
- R7: Parity (bit 2) is set when `result[7:0]` holds an even number of ones, in both sizes.
- R8: AND and XOR clear carry, auxiliary carry and overflow, and update zero, sign and parity from the result.
- R9: Status flags are written only on a clock edge with `upd_en` high and are visible in `flags` from that edge on. With `upd_en` low, all six status bits hold.
- R10: Single-step (bit 8), interrupt-enable (bit 9) and direction (bit 10) are set by their set input and cleared by their clear input on the next edge. Clear wins when both are high. The control flags hold otherwise, whatever the arithmetic does.
- R11: Unused bits of `flags` are fixed: bit 1 reads 1, and bits 3, 5 and 15:12 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sel | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| size_byte | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| upd_en | input | 1 | Capture status flags at this edge |
| df_set | input | 1 | Set direction flag |
| df_clr | input | 1 | Clear direction flag |
| if_set | input | 1 | Set interrupt-enable flag |
| if_clr | input | 1 | Clear interrupt-enable flag |
| tf_set | input | 1 | Set single-step flag |
| tf_clr | input | 1 | Clear single-step flag |
| result | output | 16 | Operation result |
| flags | output | 16 | Flags word |

## Verification
`result` is due in the same cycle as its operands. The bench therefore samples it one time unit after driving the inputs at a falling edge. Status and control flags are due one edge later. The bench checks `flags` at the next falling edge, after the single rising edge that captured them. The hold cases for status and control flags are observed at that same falling edge, against the value the previous operation left behind.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;
  localparam int FLAG_W = 16;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int DF_BIT = 10;
  localparam int OF_BIT = 11;

  localparam int CTRL_N = 3;
  localparam int CTRL_LO = TF_BIT;

  localparam logic [FLAG_W-1:0] FIXED_ONES  = 16'h0002;
  localparam logic [FLAG_W-1:0] STATUS_MASK = 16'h08D5;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } status_t;
endpackage

// File: rtl/flag_addsub.sv
`timescale 1ns/1ps
module flag_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         aux,
  output logic         ovf
);
  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
    sum   = ext[W-1:0];
    carry = ext[W];
    // bit 4 of sum equals a4 ^ b4 ^ (carry/borrow coming out of bit 3)
    aux   = a[4] ^ b[4] ^ ext[4];
    if (sub) ovf = (a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]);
    else     ovf = (a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]);
  end
endmodule

// File: rtl/flag_status.sv
`timescale 1ns/1ps
module flag_status #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic [W-1:0] res,
  input  logic         byte_mode,
  output logic         zf,
  output logic         sf,
  output logic         pf
);
  always_comb begin
    zf = byte_mode ? (res[BW-1:0] == '0) : (res == '0);
    sf = byte_mode ? res[BW-1] : res[W-1];
    pf = ~^res[7:0];
  end
endmodule

// File: rtl/flag_reg.sv
`timescale 1ns/1ps
module flag_reg
  import alu_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  status_t             st_in,
  input  logic [CTRL_N-1:0]   ctl_set,
  input  logic [CTRL_N-1:0]   ctl_clr,
  output logic [FLAG_W-1:0]   flags
);
  status_t            st_q;
  logic [CTRL_N-1:0]  ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= '0;
    else if (upd_en) st_q <= st_in;
  end

  for (genvar i = 0; i < CTRL_N; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n)          ctl_q[i] <= 1'b0;
      else if (ctl_clr[i]) ctl_q[i] <= 1'b0;
      else if (ctl_set[i]) ctl_q[i] <= 1'b1;
    end
  end

  always_comb begin
    flags = FIXED_ONES;
    flags[CF_BIT] = st_q.cf;
    flags[PF_BIT] = st_q.pf;
    flags[AF_BIT] = st_q.af;
    flags[ZF_BIT] = st_q.zf;
    flags[SF_BIT] = st_q.sf;
    flags[OF_BIT] = st_q.of;
    flags[CTRL_LO +: CTRL_N] = ctl_q;
  end
endmodule

// File: rtl/alu_flag_gen.sv
`timescale 1ns/1ps
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        op_sel,
  input  logic              size_byte,
  input  logic              upd_en,
  input  logic              df_set,
  input  logic              df_clr,
  input  logic              if_set,
  input  logic              if_clr,
  input  logic              tf_set,
  input  logic              tf_clr,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  localparam int HI_W = DATA_W - BYTE_W;

  op_e               op;
  logic              is_sub, is_logic;
  logic [DATA_W-1:0] w_sum, logic_res, pre_res;
  logic [BYTE_W-1:0] b_sum;
  logic              w_c, w_a, w_o, b_c, b_a, b_o;
  logic              zf, sf, pf;
  status_t           st;

  always_comb begin
    op       = op_e'(op_sel);
    is_sub   = (op == OP_SUB);
    is_logic = (op == OP_AND) || (op == OP_XOR);
  end

  flag_addsub #(.W(DATA_W)) u_word (
    .a(op_a), .b(op_b), .sub(is_sub),
    .sum(w_sum), .carry(w_c), .aux(w_a), .ovf(w_o)
  );

  flag_addsub #(.W(BYTE_W)) u_byte (
    .a(op_a[BYTE_W-1:0]), .b(op_b[BYTE_W-1:0]), .sub(is_sub),
    .sum(b_sum), .carry(b_c), .aux(b_a), .ovf(b_o)
  );

  always_comb begin
    logic_res = (op == OP_AND) ? (op_a & op_b) : (op_a ^ op_b);
    pre_res   = is_logic ? logic_res : w_sum;
    if (size_byte)
      result = {{HI_W{1'b0}}, (is_logic ? logic_res[BYTE_W-1:0] : b_sum)};
    else
      result = pre_res;
  end

  flag_status #(.W(DATA_W), .BW(BYTE_W)) u_stat (
    .res(result), .byte_mode(size_byte), .zf(zf), .sf(sf), .pf(pf)
  );

  always_comb begin
    st.cf = !is_logic && (size_byte ? b_c : w_c);
    st.of = !is_logic && (size_byte ? b_o : w_o);
    st.af = !is_logic && (size_byte ? b_a : w_a);
    st.zf = zf;
    st.sf = sf;
    st.pf = pf;
  end

  flag_reg u_reg (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .st_in(st),
    .ctl_set({df_set, if_set, tf_set}),
    .ctl_clr({df_clr, if_clr, tf_clr}),
    .flags(flags)
  );
endmodule

// File: rtl/alu_flag_gen_chk.sv
`timescale 1ns/1ps
module alu_flag_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op_sel,
  input logic        size_byte,
  input logic        upd_en,
  input logic        df_set,
  input logic        df_clr,
  input logic        if_set,
  input logic        if_clr,
  input logic        tf_set,
  input logic        tf_clr,
  input logic [15:0] result,
  input logic [15:0] flags
);
  logic no_ctl;
  always_comb no_ctl = !df_set && !df_clr && !if_set && !if_clr && !tf_set && !tf_clr;

  p_byte_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    size_byte |-> result[15:8] == 8'h00);

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> flags[6] == ($past(result) == 16'h0000));

  p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> flags[7] == ($past(size_byte) ? $past(result[7]) : $past(result[15])));

  p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> flags[2] == ~^$past(result[7:0]));

  p_logic_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel[1]) |=> (!flags[0] && !flags[4] && !flags[11]));

  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags & 16'h08D5));

  p_df_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    df_clr |=> !flags[10]);

  p_df_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (df_set && !df_clr) |=> flags[10]);

  p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    no_ctl |=> $stable(flags[10:8]));

  p_fixed_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && !flags[3] && !flags[5] && flags[15:12] == 4'h0);
endmodule

bind alu_flag_gen alu_flag_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .size_byte(size_byte),
  .upd_en(upd_en), .df_set(df_set), .df_clr(df_clr), .if_set(if_set),
  .if_clr(if_clr), .tf_set(tf_set), .tf_clr(tf_clr),
  .result(result), .flags(flags)
);

// File: tb/alu_flag_gen_bench.sv
`timescale 1ns/1ps
module alu_flag_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [1:0]  op_sel = '0;
  logic        size_byte = 1'b0, upd_en = 1'b0;
  logic        df_set = 0, df_clr = 0, if_set = 0, if_clr = 0, tf_set = 0, tf_clr = 0;
  logic [15:0] result, flags;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  alu_flag_gen u_alu_flag_gen (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .size_byte(size_byte), .upd_en(upd_en),
    .df_set(df_set), .df_clr(df_clr), .if_set(if_set), .if_clr(if_clr),
    .tf_set(tf_set), .tf_clr(tf_clr), .result(result), .flags(flags)
  );

  // {op, byte, a, b, expected result, expected flags}
  localparam int NV = 13;
  localparam logic [66:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'h0001, 16'h0001, 16'h0002, 16'h0002},
    {2'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0057},
    {2'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 16'h0896},
    {2'd1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 16'h0097},
    {2'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 16'h0816},
    {2'd0, 1'b1, 16'h12FF, 16'h3401, 16'h0000, 16'h0057},
    {2'd0, 1'b1, 16'h007F, 16'h0001, 16'h0080, 16'h0892},
    {2'd1, 1'b1, 16'h0050, 16'h0070, 16'h00E0, 16'h0083},
    {2'd2, 1'b0, 16'hF0F0, 16'h0FFF, 16'h00F0, 16'h0006},
    {2'd3, 1'b0, 16'h8001, 16'h0001, 16'h8000, 16'h0086},
    {2'd3, 1'b0, 16'h1234, 16'h1234, 16'h0000, 16'h0046},
    {2'd2, 1'b1, 16'hFF80, 16'h00C0, 16'h0080, 16'h0082},
    {2'd0, 1'b0, 16'h0008, 16'h0008, 16'h0010, 16'h0012}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, result due at once, flags after the next rising edge
  task automatic run_op(input logic [1:0] op, input logic bsel, input logic [15:0] a,
                        input logic [15:0] b, input logic upd);
    @(negedge clk);
    op_sel = op; size_byte = bsel; op_a = a; op_b = b; upd_en = upd;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    upd_en = 0; df_set = 0; df_clr = 0; if_set = 0; if_clr = 0; tf_set = 0; tf_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", flags, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 R11 flags after reset", flags, 16'h0002);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][66:65], VEC[i][64], VEC[i][63:48], VEC[i][47:32], 1'b1);
      check($sformatf("R2 result vec %0d", i), result, VEC[i][31:16]);
      settle();
      check($sformatf("R3 R4 R5 R6 R7 R8 R11 flags vec %0d", i), flags, VEC[i][15:0]);
    end

    // R9: update disabled, carry-producing add leaves status unchanged (last vec: 0x0012)
    run_op(2'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b0);
    check("R2 result without update", result, 16'h0000);
    settle();
    check("R9 status held", flags, 16'h0012);

    // R10: set direction flag
    @(negedge clk); df_set = 1;
    settle();
    check("R10 direction set", flags, 16'h0412);
    // arithmetic leaves the control flag alone
    run_op(2'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b1);
    settle();
    check("R10 control kept over arithmetic", flags, 16'h0457);
    // set interrupt-enable and single-step
    @(negedge clk); if_set = 1; tf_set = 1;
    settle();
    check("R10 all control set", flags, 16'h0757);
    // hold with no control input
    @(negedge clk);
    check("R10 control hold", flags, 16'h0757);
    // clear wins over set
    @(negedge clk); df_set = 1; df_clr = 1;
    settle();
    check("R10 clear priority", flags, 16'h0357);
    @(negedge clk); if_clr = 1; tf_clr = 1;
    settle();
    check("R10 control cleared", flags, 16'h0057);

    // byte subtract with borrow from bit 3 only
    run_op(2'd1, 1'b1, 16'hAB10, 16'h0001, 1'b1);
    check("R2 byte result upper zero", result, 16'h000F);
    settle();
    check("R4 byte half borrow", flags, 16'h0016);

    // reset in the middle returns everything to its initial word
    @(negedge clk); df_set = 1;
    settle();
    rst_n = 0;
    @(negedge clk);
    check("R1 second reset", flags, 16'h0002);
    rst_n = 1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule